// File: doc/BRIEF.md
# Thermal Alarm and Shutdown Comparator

This block watches up to four temperature-sensor channels. Each channel delivers a 12-bit code, and a lower code means a hotter die. On every update strobe for a channel, the block compares the new code with three thresholds stored for that channel:

- An alarm-entry code.
- An alarm-release code, which provides hysteresis.
- A shutdown code.

When either condition becomes true, the block sets a sticky status bit. Software clears a status bit by writing 1 to it. A single interrupt line is raised whenever an enabled status bit is set.

Software programs the thresholds and the interrupt enables through a simple word-addressed register port. Reads are registered and return one cycle after the read request. The block does not convert codes to temperatures and does not decide what to do about an overheat. It only detects and flags the conditions.

Top module: `therm_guard`

## Requirements
- R1: After reset, every threshold, every enable and every status bit is zero. `irq_o` is low, and reads of offsets 0x44, 0x48, 0x50 and 0x60 return 0.
- R2: The register layout is as follows. Unused bits read as zero, and a read returns data one cycle after `reg_rd_i`.
  - The alarm register of sensor i sits at offset 0x50+4*i. It holds the alarm-entry code in bits 27:16 and the release (hysteresis) code in bits 11:0.
  - The shutdown register of sensor i sits at offset 0x60+4*i. It holds the shutdown code in bits 27:16.
  - The enable register sits at offset 0x44, and the status register sits at offset 0x48.
- R3: On a strobe whose code is at or below a nonzero alarm-entry code, the alarm condition of that sensor becomes active.
- R4: An active alarm condition stays active on strobes with codes up to and including the release code. It goes inactive only on a strobe whose code is strictly above the release code.
- R5: The shutdown condition is active exactly when the last strobed code is at or below a nonzero shutdown code. It has no hysteresis.
- R6: The status bits are placed as follows:
  - Alarm status for sensor i is bit i of the status register.
  - Shutdown status for sensor i is bit 4+i.
  - A status bit is set in the clock edge that samples a strobe making its condition go from inactive to active.
  - A status bit stays set after the condition goes away.
- R7: Writing 1 to a status bit clears it, and writing 0 leaves it unchanged. If a new rising condition and a clear of the same bit fall in the same cycle, the bit ends up set.
- R8: `irq_o` is high exactly when some status bit is set and the enable bit at the same position in the enable register is also set.
- R9: A threshold of zero disables its comparison. A zero alarm-release code makes the alarm release when the code rises above the entry code.
- R10: Code inputs are sampled only on the sensor's own strobe. A code change without a strobe has no effect on conditions or status.
- R11: A condition that is still active after its status bit was cleared does not set the bit again. It must first go inactive and then become active again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| code_i | input | NUM_SENS*12 | Sensor codes, sensor i in bits [12*i+11:12*i] |
| code_vld_i | input | NUM_SENS | Per-sensor update strobe |
| reg_wr_i | input | 1 | Register write request |
| reg_rd_i | input | 1 | Register read request |
| reg_addr_i | input | ADDR_W | Byte offset of the register |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data, valid with reg_rvld_o |
| reg_rvld_o | output | 1 | Read data valid, one cycle after reg_rd_i |
| irq_o | output | 1 | Interrupt request |

## Verification
The channel assertions assume the following about the inputs:
- The code bus is stable and free of unknowns whenever a strobe is high.
- The hysteresis relation only has meaning when the release code is numerically at or above the entry code.

The stimulus follows these limits. It changes every input only on the falling clock edge and always programs release codes at or above entry codes. The status assertions accept a clear write and a strobe in the same cycle, and the stimulus deliberately produces that coincidence once. `NUM_SENS` is assumed to be at most four, so that the alarm bits and shutdown bits never overlap.

// File: rtl/therm_guard_pkg.sv
package therm_guard_pkg;

  localparam int unsigned CODE_W     = 12;
  localparam int unsigned REG_W      = 32;
  localparam int unsigned HOT_LSB    = 16;
  localparam int unsigned ALM_ST_LSB = 0;
  localparam int unsigned SHT_ST_LSB = 4;

  localparam int unsigned OFS_IEN  = 'h44;
  localparam int unsigned OFS_STAT = 'h48;
  localparam int unsigned OFS_ALM  = 'h50;
  localparam int unsigned OFS_SHT  = 'h60;
  localparam int unsigned OFS_STEP = 4;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    code_t entry;
    code_t leave;
    code_t trip;
  } thr_t;

  // a code at or below a nonzero limit counts as hot
  function automatic logic code_is_hot(code_t code, code_t lim);
    return (lim != '0) && (code <= lim);
  endfunction

  // code above which an active alarm drops
  function automatic code_t release_level(code_t entry, code_t leave);
    return (leave != '0) ? leave : entry;
  endfunction

  function automatic logic alarm_step(logic cur, code_t code, code_t entry, code_t leave);
    if (entry == '0) return 1'b0;
    if (code <= entry) return 1'b1;
    if (code > release_level(entry, leave)) return 1'b0;
    return cur;
  endfunction

endpackage

// File: rtl/therm_guard_chan.sv
module therm_guard_chan
  import therm_guard_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  logic  vld_i,
  input  code_t code_i,
  input  thr_t  thr_i,
  output logic  alm_act_o,
  output logic  sht_act_o,
  output logic  alm_rise_o,
  output logic  sht_rise_o
);

  logic alm_q, sht_q;
  logic alm_d, sht_d;

  always_comb begin
    alm_d = alarm_step(alm_q, code_i, thr_i.entry, thr_i.leave);
    sht_d = code_is_hot(code_i, thr_i.trip);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_q <= 1'b0;
      sht_q <= 1'b0;
    end else if (vld_i) begin
      alm_q <= alm_d;
      sht_q <= sht_d;
    end
  end

  assign alm_rise_o = vld_i & alm_d & ~alm_q;
  assign sht_rise_o = vld_i & sht_d & ~sht_q;
  assign alm_act_o  = alm_q;
  assign sht_act_o  = sht_q;

  a_r3_enter: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && thr_i.entry != '0 && code_i <= thr_i.entry |=> alm_q);

  // R4: codes between entry and release keep the alarm
  a_r4_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && alm_q && thr_i.entry != '0 && thr_i.leave != '0 &&
    code_i > thr_i.entry && code_i <= thr_i.leave |=> alm_q);

  a_r5_trip_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && code_i > thr_i.trip |=> !sht_q);

  a_r9_alarm_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    vld_i && thr_i.entry == '0 |=> !alm_q);

  a_r10_no_strobe: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vld_i |=> $stable(alm_q) && $stable(sht_q));

endmodule

// File: rtl/therm_guard_regs.sv
module therm_guard_regs
  import therm_guard_pkg::*;
#(
  parameter int unsigned NS     = 3,
  parameter int unsigned ADDR_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [REG_W-1:0]  wdata_i,
  input  logic [NS-1:0]     alm_rise_i,
  input  logic [NS-1:0]     sht_rise_i,
  output thr_t [NS-1:0]     thr_o,
  output logic [REG_W-1:0]  rdata_o,
  output logic              rvld_o,
  output logic              irq_o
);

  thr_t [NS-1:0]    thr_q;
  logic [NS-1:0]    alm_en_q, sht_en_q, alm_st_q, sht_st_q;
  logic [REG_W-1:0] rd_mux, rdata_q;
  logic             rvld_q;
  logic             en_wr, st_wr;
  logic [NS-1:0]    alm_clr, sht_clr;
  logic             unused_wdata;

  function automatic logic [ADDR_W-1:0] alm_addr(int unsigned i);
    return ADDR_W'(OFS_ALM + OFS_STEP * i);
  endfunction

  function automatic logic [ADDR_W-1:0] sht_addr(int unsigned i);
    return ADDR_W'(OFS_SHT + OFS_STEP * i);
  endfunction

  assign en_wr   = wr_i && (addr_i == ADDR_W'(OFS_IEN));
  assign st_wr   = wr_i && (addr_i == ADDR_W'(OFS_STAT));
  assign alm_clr = st_wr ? wdata_i[ALM_ST_LSB +: NS] : '0;
  assign sht_clr = st_wr ? wdata_i[SHT_ST_LSB +: NS] : '0;
  assign unused_wdata = ^wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      thr_q <= '0;
    end else if (wr_i) begin
      for (int unsigned i = 0; i < NS; i++) begin
        if (addr_i == alm_addr(i)) begin
          thr_q[i].entry <= wdata_i[HOT_LSB +: CODE_W];
          thr_q[i].leave <= wdata_i[0 +: CODE_W];
        end
        if (addr_i == sht_addr(i)) begin
          thr_q[i].trip <= wdata_i[HOT_LSB +: CODE_W];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_en_q <= '0;
      sht_en_q <= '0;
    end else if (en_wr) begin
      alm_en_q <= wdata_i[ALM_ST_LSB +: NS];
      sht_en_q <= wdata_i[SHT_ST_LSB +: NS];
    end
  end

  // a new rising condition wins over a clear in the same cycle
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alm_st_q <= '0;
      sht_st_q <= '0;
    end else begin
      alm_st_q <= (alm_st_q & ~alm_clr) | alm_rise_i;
      sht_st_q <= (sht_st_q & ~sht_clr) | sht_rise_i;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (addr_i == ADDR_W'(OFS_IEN)) begin
      rd_mux[ALM_ST_LSB +: NS] = alm_en_q;
      rd_mux[SHT_ST_LSB +: NS] = sht_en_q;
    end
    if (addr_i == ADDR_W'(OFS_STAT)) begin
      rd_mux[ALM_ST_LSB +: NS] = alm_st_q;
      rd_mux[SHT_ST_LSB +: NS] = sht_st_q;
    end
    for (int unsigned i = 0; i < NS; i++) begin
      if (addr_i == alm_addr(i)) begin
        rd_mux[HOT_LSB +: CODE_W] = thr_q[i].entry;
        rd_mux[0 +: CODE_W]       = thr_q[i].leave;
      end
      if (addr_i == sht_addr(i)) begin
        rd_mux[HOT_LSB +: CODE_W] = thr_q[i].trip;
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q <= '0;
      rvld_q  <= 1'b0;
    end else begin
      rvld_q <= rd_i;
      if (rd_i) rdata_q <= rd_mux;
    end
  end

  assign thr_o   = thr_q;
  assign rdata_o = rdata_q;
  assign rvld_o  = rvld_q;
  assign irq_o   = (|(alm_st_q & alm_en_q)) | (|(sht_st_q & sht_en_q));

  a_r2_read_lat: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_i |=> rvld_o);

  a_r8_irq_needs_status: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> (|alm_st_q) || (|sht_st_q));

  for (genvar b = 0; b < NS; b++) begin : g_chk
    a_r6_alm_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alm_st_q[b] && !alm_clr[b] |=> alm_st_q[b]);
    a_r6_sht_sticky: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sht_st_q[b] && !sht_clr[b] |=> sht_st_q[b]);
    a_r7_alm_set_wins: assert property (@(posedge clk_i) disable iff (!rst_ni)
      alm_rise_i[b] |=> alm_st_q[b]);
    a_r7_sht_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
      sht_clr[b] && !sht_rise_i[b] |=> !sht_st_q[b]);
  end

endmodule

// File: rtl/therm_guard.sv
module therm_guard
  import therm_guard_pkg::*;
#(
  parameter int unsigned NUM_SENS = 3,
  parameter int unsigned ADDR_W   = 8
) (
  input  logic                       clk_i,
  input  logic                       rst_ni,
  input  logic [NUM_SENS*CODE_W-1:0] code_i,
  input  logic [NUM_SENS-1:0]        code_vld_i,
  input  logic                       reg_wr_i,
  input  logic                       reg_rd_i,
  input  logic [ADDR_W-1:0]          reg_addr_i,
  input  logic [REG_W-1:0]           reg_wdata_i,
  output logic [REG_W-1:0]           reg_rdata_o,
  output logic                       reg_rvld_o,
  output logic                       irq_o
);

  thr_t [NUM_SENS-1:0] thr;
  logic [NUM_SENS-1:0] alm_rise, sht_rise, alm_act, sht_act;

  for (genvar i = 0; i < NUM_SENS; i++) begin : g_chan
    therm_guard_chan u_chan (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .vld_i      (code_vld_i[i]),
      .code_i     (code_i[i*CODE_W +: CODE_W]),
      .thr_i      (thr[i]),
      .alm_act_o  (alm_act[i]),
      .sht_act_o  (sht_act[i]),
      .alm_rise_o (alm_rise[i]),
      .sht_rise_o (sht_rise[i])
    );
  end

  therm_guard_regs #(
    .NS     (NUM_SENS),
    .ADDR_W (ADDR_W)
  ) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (reg_wr_i),
    .rd_i       (reg_rd_i),
    .addr_i     (reg_addr_i),
    .wdata_i    (reg_wdata_i),
    .alm_rise_i (alm_rise),
    .sht_rise_i (sht_rise),
    .thr_o      (thr),
    .rdata_o    (reg_rdata_o),
    .rvld_o     (reg_rvld_o),
    .irq_o      (irq_o)
  );

  // R11: a rise only comes from an inactive condition
  a_r11_rise_from_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|(alm_rise & alm_act)) == 1'b0 && (|(sht_rise & sht_act)) == 1'b0);

endmodule

// File: tb/sim_therm_guard.sv
module sim_therm_guard;
  import therm_guard_pkg::*;

  localparam int NS = 3;
  localparam int AW = 8;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic [NS*CODE_W-1:0] code = '0;
  logic [NS-1:0]        vld = '0;
  logic                 wr = 1'b0, rd = 1'b0;
  logic [AW-1:0]        addr = '0;
  logic [31:0]          wdata = '0;
  wire  [31:0]          rdata;
  wire                  rvld, irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  therm_guard #(.NUM_SENS(NS), .ADDR_W(AW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .code_i(code), .code_vld_i(vld),
    .reg_wr_i(wr), .reg_rd_i(rd), .reg_addr_i(addr), .reg_wdata_i(wdata),
    .reg_rdata_o(rdata), .reg_rvld_o(rvld), .irq_o(irq)
  );

  // monitor: pops one expected item per returned read
  always @(negedge clk) begin : mon
    logic [31:0] e;
    string t;
    if (rst_n && rvld) begin
      checks++;
      if (exp_q.size() == 0) begin
        errors++;
        $display("FAIL R2 unexpected read actual %h expected none", rdata);
      end else begin
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rdata !== e) begin
          errors++;
          $display("FAIL %s actual %h expected %h", t, rdata, e);
        end
      end
    end
  end

  task automatic wr_reg(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic rd_reg(input logic [7:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e); tag_q.push_back(t);
    @(negedge clk); rd = 1'b1; addr = a;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic strobe(input int s, input logic [11:0] c);
    @(negedge clk); code[s*CODE_W +: CODE_W] = c; vld[s] = 1'b1;
    @(negedge clk); vld = '0;
  endtask

  task automatic chk_irq(input logic e, input string t);
    @(negedge clk);
    checks++;
    if (irq !== e) begin
      errors++;
      $display("FAIL %s irq actual %b expected %b", t, irq, e);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(negedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual hung expected finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin : drive
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    rd_reg(8'h44, 32'h0, "R1 enable");
    rd_reg(8'h48, 32'h0, "R1 status");
    rd_reg(8'h50, 32'h0, "R1 alarm0");
    rd_reg(8'h60, 32'h0, "R1 shut0");
    chk_irq(1'b0, "R1");

    // R2 layout and unused bits
    wr_reg(8'h50, 32'hF300_F380);
    rd_reg(8'h50, 32'h0300_0380, "R2 alarm0");
    wr_reg(8'h68, 32'h01F0_FFFF);
    rd_reg(8'h68, 32'h01F0_0000, "R2 shut2");
    wr_reg(8'h44, 32'hFFFF_FFFF);
    rd_reg(8'h44, 32'h0000_0077, "R2 enable");
    wr_reg(8'h44, 32'h0000_0077);

    // R10 code change without strobe
    @(negedge clk); code[0 +: CODE_W] = 12'h100;
    repeat (4) @(negedge clk);
    rd_reg(8'h48, 32'h0, "R10 no strobe");
    chk_irq(1'b0, "R10");

    // R3 entry at the boundary, R8 irq
    strobe(0, 12'h300);
    rd_reg(8'h48, 32'h01, "R3 alarm0 set");
    chk_irq(1'b1, "R8 enabled");

    // R7 write-one-to-clear
    wr_reg(8'h48, 32'h0);
    rd_reg(8'h48, 32'h01, "R7 write zero keeps");
    wr_reg(8'h48, 32'h01);
    rd_reg(8'h48, 32'h0, "R7 clear");
    chk_irq(1'b0, "R7");

    // R4 / R11 hysteresis
    strobe(0, 12'h350);
    strobe(0, 12'h2F0);
    strobe(0, 12'h380);
    strobe(0, 12'h2F0);
    rd_reg(8'h48, 32'h0, "R11 R4 held no rerise");
    strobe(0, 12'h381);
    strobe(0, 12'h300);
    rd_reg(8'h48, 32'h01, "R4 released then re-entered");

    // R6 sticky
    strobe(0, 12'h800);
    rd_reg(8'h48, 32'h01, "R6 sticky");
    wr_reg(8'h48, 32'h01);

    // R8 gating by enable
    wr_reg(8'h44, 32'h70);
    strobe(0, 12'h200);
    rd_reg(8'h48, 32'h01, "R8 status set");
    chk_irq(1'b0, "R8 disabled bit");
    wr_reg(8'h48, 32'h01);

    // R5 shutdown, no hysteresis; R9 alarm2 disabled
    strobe(2, 12'h1F1);
    rd_reg(8'h48, 32'h0, "R5 above trip");
    strobe(2, 12'h1F0);
    rd_reg(8'h48, 32'h40, "R5 R9 trip only");
    chk_irq(1'b1, "R5");
    wr_reg(8'h48, 32'h40);
    chk_irq(1'b0, "R5 cleared");
    strobe(2, 12'h1F0);
    rd_reg(8'h48, 32'h0, "R11 level no rerise");
    strobe(2, 12'h1F1);
    strobe(2, 12'h1F0);
    rd_reg(8'h48, 32'h40, "R5 rerise");
    wr_reg(8'h48, 32'h40);

    // R9 zero thresholds
    strobe(1, 12'h000);
    strobe(2, 12'h000);
    rd_reg(8'h48, 32'h0, "R9 zero thresholds");

    // R9 zero release code
    wr_reg(8'h54, 32'h0400_0000);
    strobe(1, 12'h3FF);
    rd_reg(8'h48, 32'h02, "R9 alarm1 set");
    wr_reg(8'h48, 32'h02);
    strobe(1, 12'h400);
    rd_reg(8'h48, 32'h0, "R9 held at entry");
    strobe(1, 12'h401);
    strobe(1, 12'h400);
    rd_reg(8'h48, 32'h02, "R9 release above entry");
    wr_reg(8'h48, 32'h02);

    // R7 set wins over clear
    wr_reg(8'h64, 32'h0200_0000);
    strobe(1, 12'h300);
    rd_reg(8'h48, 32'h0, "R7 setup");
    @(negedge clk);
    code[CODE_W +: CODE_W] = 12'h100; vld[1] = 1'b1;
    wr = 1'b1; addr = 8'h48; wdata = 32'h20;
    @(negedge clk);
    vld = '0; wr = 1'b0;
    rd_reg(8'h48, 32'h20, "R7 set wins");
    chk_irq(1'b1, "R7 set wins");

    wr_reg(8'h48, 32'hFF);
    rd_reg(8'h48, 32'h0, "R7 clear all");
    chk_irq(1'b0, "R8 all clear");

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL R2 reads missing actual %0d expected 0", exp_q.size());
    end
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule